// File: doc/BRIEF.md
# Multi-Stage Trigger Sequencer

This block watches a parallel trigger input bus and walks through an ordered program of trigger stages held in a small on-chip buffer. Each stage carries a select mask and an expected bit value. Before any comparison, the raw inputs are conditioned: each bit can be inverted, and each bit can be forced to zero by an enable mask. The sequencer waits at the current stage until the conditioned bits under that stage's mask equal the stage's expected value. It then moves to the next stage on the following clock. Once the final stage of the program is met, it raises a single-cycle fire pulse.

Software or a control block fills the stage buffer through a one-entry write port. It sets the number of active stages and pulses the arm input. While the program runs, the block reports a busy flag and the index of the stage it is waiting on. The control logic is a three-state machine. IDLE waits for arm. RUN evaluates the stage at the current index. FIRE lasts exactly one cycle and drives the pulse. Arm moves the machine from IDLE or FIRE into RUN, or straight into FIRE when the program length is zero. Arm received in RUN restarts the program at stage 0. A match on the last stage moves RUN to FIRE. FIRE falls back to IDLE unless arm is present.

Top module: `trig_seq`

## Requirements
- R1: The conditioned input is `(trig_in ^ inv_mask) & en_mask`, computed bit by bit. A set bit in `inv_mask` inverts that input bit, and a clear bit in `en_mask` forces it to 0.
- R2: A stage at buffer address `a` is met when `(cond & mask[a]) == (pat[a] & mask[a])`. Input bits outside the stage mask have no effect.
- R3: Stages are taken strictly in index order, at most one per clock. A match sampled at a clock edge raises `stage_idx` by one after that edge. Two consecutive stages are never met by the same input sample.
- R4: When the last active stage (index `len-1`) is met at a clock edge, `fire` is high for exactly the following cycle and `busy` is low in that cycle.
- R5: Arm sampled at a clock edge with a nonzero length sets `busy` to 1 and `stage_idx` to 0 after that edge. This also applies when the block is already running, in which case the program restarts from stage 0.
- R6: Arm with `prog_len` equal to 0 makes `fire` high in the cycle right after the arm edge, and `busy` stays 0.
- R7: After firing, the block returns to IDLE (`busy` 0, `fire` 0) and does not fire again, whatever the inputs, until it is re-armed.
- R8: A stage buffer write (`wr_en` high) is ignored while `busy` is 1. When `busy` is 0, the write stores `wr_mask` and `wr_pat` at `wr_addr`.
- R9: After reset, `fire` is 0, `busy` is 0 and `stage_idx` is 0.
- R10: `prog_len` is captured at the arm edge. Changing it during a run does not change which stage ends the program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Start or restart the stage program |
| prog_len | input | LW | Number of active stages, captured at arm |
| inv_mask | input | W | Per-bit input inversion |
| en_mask | input | W | Per-bit input enable |
| trig_in | input | W | Raw trigger bus |
| wr_en | input | 1 | Stage buffer write strobe |
| wr_addr | input | AW | Stage buffer write address |
| wr_mask | input | W | Select mask written to the stage |
| wr_pat | input | W | Expected value written to the stage |
| fire | output | 1 | One-cycle trigger pulse |
| busy | output | 1 | Program running |
| stage_idx | output | AW | Index of the stage being evaluated |

## Verification
The bench builds the block with an 8-bit trigger bus and a stage buffer of 8 entries. With only 8 entries, a program that uses every entry can run to the last buffer address and fire within a few cycles. That makes the full-length case and the index boundary reachable in a directed test. The 8-bit bus still leaves room to exercise inversion, enable and mask bits on separate bit positions in one stimulus word.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIRE = 2'd2
    } seq_state_t;

endpackage

// File: rtl/trig_cond.sv
module trig_cond #(
    parameter int W = 8
) (
    input  logic [W-1:0] raw,
    input  logic [W-1:0] inv_mask,
    input  logic [W-1:0] en_mask,
    output logic [W-1:0] cond
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        assign cond[b] = (raw[b] ^ inv_mask[b]) & en_mask[b];
    end
endmodule

// File: rtl/trig_stage_mem.sv
module trig_stage_mem #(
    parameter int W     = 8,
    parameter int DEPTH = 256,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wmask,
    input  logic [W-1:0]  wpat,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rmask,
    output logic [W-1:0]  rpat
);
    logic [W-1:0] mask_q [DEPTH];
    logic [W-1:0] pat_q  [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mask_q[waddr] <= wmask;
            pat_q[waddr]  <= wpat;
        end
    end

    assign rmask = mask_q[raddr];
    assign rpat  = pat_q[raddr];
endmodule

// File: rtl/trig_match.sv
module trig_match #(
    parameter int W = 8
) (
    input  logic [W-1:0] cond,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] pat,
    output logic         hit
);
    assign hit = ((cond & mask) == (pat & mask));
endmodule

// File: rtl/trig_seq.sv
module trig_seq
    import trig_seq_pkg::*;
#(
    parameter int W     = 8,
    parameter int DEPTH = 256,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic [LW-1:0] prog_len,
    input  logic [W-1:0]  inv_mask,
    input  logic [W-1:0]  en_mask,
    input  logic [W-1:0]  trig_in,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_mask,
    input  logic [W-1:0]  wr_pat,
    output logic          fire,
    output logic          busy,
    output logic [AW-1:0] stage_idx
);
    seq_state_t    state_q, state_n;
    logic [AW-1:0] idx_q, idx_n;
    logic [LW-1:0] len_q;
    logic [W-1:0]  cond;
    logic [W-1:0]  st_mask, st_pat;
    logic          hit, last, mem_we;

    trig_cond #(.W(W)) u_cond (
        .raw      (trig_in),
        .inv_mask (inv_mask),
        .en_mask  (en_mask),
        .cond     (cond)
    );

    // Buffer accepts writes only when no program is running.
    assign mem_we = wr_en && (state_q != ST_RUN);

    trig_stage_mem #(.W(W), .DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (wr_addr),
        .wmask (wr_mask),
        .wpat  (wr_pat),
        .raddr (idx_q),
        .rmask (st_mask),
        .rpat  (st_pat)
    );

    trig_match #(.W(W)) u_match (
        .cond (cond),
        .mask (st_mask),
        .pat  (st_pat),
        .hit  (hit)
    );

    assign last = (LW'(idx_q) == (len_q - LW'(1)));

    // Next-state logic
    always_comb begin
        state_n = state_q;
        idx_n   = idx_q;
        unique case (state_q)
            ST_IDLE, ST_FIRE: begin
                if (arm) begin
                    state_n = (prog_len == '0) ? ST_FIRE : ST_RUN;
                    idx_n   = '0;
                end else begin
                    state_n = ST_IDLE;
                end
            end
            ST_RUN: begin
                if (arm) begin
                    state_n = (prog_len == '0) ? ST_FIRE : ST_RUN;
                    idx_n   = '0;
                end else if (hit) begin
                    if (last) state_n = ST_FIRE;
                    else      idx_n   = idx_q + AW'(1);
                end
            end
            default: begin
                state_n = ST_IDLE;
                idx_n   = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            len_q   <= '0;
        end else begin
            state_q <= state_n;
            idx_q   <= idx_n;
            if (arm) len_q <= prog_len;
        end
    end

    // Outputs
    always_comb begin
        fire = 1'b0;
        busy = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RUN:  busy = 1'b1;
            ST_FIRE: fire = 1'b1;
            default: ;
        endcase
    end

    assign stage_idx = idx_q;
endmodule

// File: rtl/trig_seq_chk.sv
module trig_seq_chk #(
    parameter int W     = 8,
    parameter int DEPTH = 256,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          arm,
    input logic [LW-1:0] prog_len,
    input logic          fire,
    input logic          busy,
    input logic [AW-1:0] stage_idx
);
    AST_FIRE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) fire |-> !busy); // R4
    AST_FIRE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) (fire && !arm) |=> !fire); // R7
    AST_ARM_START: assert property (@(posedge clk) disable iff (!rst_n) (arm && prog_len != '0) |=> (busy && stage_idx == '0)); // R5
    AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n) (arm && prog_len == '0) |=> (fire && !busy)); // R6
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n) (busy && !arm) |=> (!busy || stage_idx == $past(stage_idx) || stage_idx == $past(stage_idx) + AW'(1))); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !fire && !arm) |=> !fire); // R7
endmodule

bind trig_seq trig_seq_chk #(.W(W), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/sim_trig_seq.sv
module sim_trig_seq;
    localparam int W     = 8;
    localparam int DEPTH = 8;
    localparam int AW    = $clog2(DEPTH);
    localparam int LW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          arm = 1'b0;
    logic [LW-1:0] prog_len = '0;
    logic [W-1:0]  inv_mask = '0;
    logic [W-1:0]  en_mask = '1;
    logic [W-1:0]  trig_in = '0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [W-1:0]  wr_mask = '0;
    logic [W-1:0]  wr_pat = '0;
    logic          fire, busy;
    logic [AW-1:0] stage_idx;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    trig_seq #(.W(W), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .arm(arm), .prog_len(prog_len),
        .inv_mask(inv_mask), .en_mask(en_mask), .trig_in(trig_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_mask(wr_mask), .wr_pat(wr_pat),
        .fire(fire), .busy(busy), .stage_idx(stage_idx)
    );

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Advance one edge; return 1 time unit after it.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr_stage(int a, logic [W-1:0] m, logic [W-1:0] p);
        wr_en = 1'b1; wr_addr = AW'(a); wr_mask = m; wr_pat = p;
        step();
        wr_en = 1'b0;
    endtask

    task automatic do_arm(int len);
        prog_len = LW'(len); arm = 1'b1;
        step();
        arm = 1'b0;
    endtask

    task automatic t_reset();
        check("R9 fire", fire, 0);
        check("R9 busy", busy, 0);
        check("R9 idx", stage_idx, 0);
    endtask

    task automatic t_basic();
        inv_mask = '0; en_mask = '1; trig_in = 8'h00;
        wr_stage(0, 8'hFF, 8'h01);
        wr_stage(1, 8'h0F, 8'h02);
        wr_stage(2, 8'h80, 8'h80);
        do_arm(3);
        check("R5 busy", busy, 1);
        check("R5 idx", stage_idx, 0);
        step(); step();
        check("R2 no match idx", stage_idx, 0);
        trig_in = 8'h01; step();
        check("R3 advance", stage_idx, 1);
        step();
        check("R3 hold", stage_idx, 1);
        trig_in = 8'hF2; step();
        check("R2 masked bits", stage_idx, 2);
        trig_in = 8'h80; step();
        check("R4 fire", fire, 1);
        check("R4 busy low", busy, 0);
        step();
        check("R7 single pulse", fire, 0);
        for (int i = 0; i < 4; i++) begin
            step();
            check("R7 no refire", fire, 0);
        end
        trig_in = 8'h00;
    endtask

    task automatic t_same_sample();
        wr_stage(0, 8'hFF, 8'h55);
        wr_stage(1, 8'hFF, 8'h55);
        trig_in = 8'h55;
        do_arm(2);
        check("R3 idx0", stage_idx, 0);
        step();
        check("R3 one stage per clock", stage_idx, 1);
        check("R3 not fired yet", fire, 0);
        step();
        check("R4 fire after stage1", fire, 1);
        trig_in = 8'h00;
        step();
    endtask

    task automatic t_condition();
        wr_stage(0, 8'hFF, 8'hA0);
        inv_mask = 8'h0F; en_mask = 8'hF0;
        trig_in = 8'h50;
        do_arm(1);
        step();
        check("R1 mismatch", fire, 0);
        check("R1 still busy", busy, 1);
        trig_in = 8'hA5; step();
        check("R1 inv+en match", fire, 1);
        step();
        wr_stage(0, 8'h80, 8'h00);
        inv_mask = 8'h80; en_mask = 8'hFF;
        trig_in = 8'h00;
        do_arm(1);
        step();
        check("R1 inverted bit blocks", fire, 0);
        trig_in = 8'h80; step();
        check("R1 inverted bit matches", fire, 1);
        inv_mask = '0; trig_in = '0;
        step();
    endtask

    task automatic t_zero_len();
        do_arm(0);
        check("R6 fire", fire, 1);
        check("R6 busy", busy, 0);
        step();
        check("R6 pulse ends", fire, 0);
    endtask

    task automatic t_write_ignored();
        wr_stage(0, 8'hFF, 8'h11);
        trig_in = 8'h00;
        do_arm(1);
        wr_stage(0, 8'h00, 8'h00);
        check("R8 write while busy ignored", busy, 1);
        step();
        check("R8 no fire", fire, 0);
        trig_in = 8'h11; step();
        check("R8 old stage used", fire, 1);
        step();
        trig_in = 8'h00;
        wr_stage(0, 8'h00, 8'h00);
        do_arm(1);
        step();
        check("R8 idle write taken", fire, 1);
        step();
    endtask

    task automatic t_len_latch();
        wr_stage(0, 8'hFF, 8'h01);
        wr_stage(1, 8'hFF, 8'h02);
        trig_in = 8'h00;
        do_arm(2);
        prog_len = LW'(1);
        trig_in = 8'h01; step();
        check("R10 no early fire", fire, 0);
        check("R10 idx", stage_idx, 1);
        // rearm mid-run restarts
        trig_in = 8'h00;
        do_arm(2);
        check("R5 restart idx", stage_idx, 0);
        check("R5 restart busy", busy, 1);
        trig_in = 8'h01; step();
        trig_in = 8'h02; step();
        check("R10 fire at captured len", fire, 1);
        trig_in = 8'h00;
        step();
    endtask

    task automatic t_full();
        for (int a = 0; a < DEPTH; a++) wr_stage(a, 8'h00, 8'h00);
        do_arm(DEPTH);
        for (int k = 0; k < DEPTH; k++) begin
            check("R3 full walk idx", stage_idx, k);
            check("R3 full walk no fire", fire, 0);
            step();
        end
        check("R4 fire at last address", fire, 1);
        step();
    endtask

    initial begin
        #40000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_basic();
        t_same_sample();
        t_condition();
        t_zero_len();
        t_write_ignored();
        t_len_latch();
        t_full();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule